// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block behaves as a small word-organised serial EEPROM. An external master drives a chip select, a serial clock and a serial data input. The block drives one serial data output. All pins are sampled by a fast system clock, and edges on chip select and serial clock are detected from registered copies of the pins. The device stores an array of 16-bit words. The array size is a parameter that can be 16, 64, 128 or 256 words.

Each transaction opens with a rising chip select. It carries a start pattern, a 2-bit command code, an address, and for writes 16 data bits, all most significant bit first. Reads stream the addressed word back on the data output. Word writes, word erases, fill and clear of the whole array take effect when chip select is released, and only after software has unlocked the device. A word write clears bits: the incoming word is ANDed into the stored one, so only an erase can set bits back to 1. When the device is not driving the output, the output sits at logic 1.

Top module: `uwire_nvm`

## Requirements
- R1: After reset the data output is 1, the device is locked, and word i holds INIT_PATTERN XOR {i[7:0], i[7:0]}.
- R2: A rising chip select restarts the frame, clearing the bit counter, command and address. Data is taken only on a rising serial clock while chip select is high, so serial clock activity with chip select low has no effect.
- R3: The start pattern is a 0 then a 1. Surplus 0 bits before the 1 are ignored. If the first sampled bit is 1, it counts as the whole start pattern and the next bit is the first command bit.
- R4: After the start pattern come 2 command bits and then the address bits. The address has 6 bits for 16- or 64-word arrays and 8 bits for 128- or 256-word arrays. The word index is the address modulo the array size.
- R5: Command 2'b10 reads. On the clock that takes the last address bit, the output drops to a 0 dummy bit. Each of the next 16 clocks then presents one bit of the stored word, MSB first.
- R6: Command 2'b00 is a special command, selected by the top two address bits: 2'b11 unlocks, 2'b00 locks, 2'b01 fills, 2'b10 clears. Lock and unlock act on the clock of the last address bit.
- R7: The array changes only on the falling edge of chip select, and only while the device is unlocked. While it is locked, all write, erase, fill and clear requests leave the array unchanged.
- R8: Command 2'b11 sets the addressed word to 16'hFFFF on release.
- R9: Command 2'b01 ANDs the 16 shifted-in data bits into the addressed word. It runs only if all 16 data bits arrived. Data clocks beyond 16 are ignored.
- R10: Special command "clear" sets every word to 16'hFFFF on release.
- R11: Special command "fill" ANDs the 16 data bits into every word on release. It runs only if all 16 data bits arrived.
- R12: After a falling chip select the data output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master, registered, idles at 1 |

## Verification
Every cycle, the assertions check the following. The output is low only while a read is in progress. The unlock state changes only on a serial clock edge that completes a special command. The array acts only when chip select falls. A word write never sets a bit, and a word erase leaves all ones. The bench's scenarios are needed for the rest, because the stored contents and the serial ordering only show at the pins. These include the start-pattern variants, address wrap-around, incomplete and over-long data phases, locked-device requests, and the bulk fill and clear. The bench compares every step against a behavioural model and reads each affected word back.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CLEAR_ALL,
    ACT_FILL_ALL,
    ACT_ERASE_WORD,
    ACT_WRITE_WORD
  } act_e;
endpackage

// File: rtl/nvm_pin_edge.sv
module nvm_pin_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] cur_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= pin_i;
      prev_q <= cur_q;
    end
  end

  assign level_o = cur_q;
  assign rise_o  = cur_q & ~prev_q;
  assign fall_o  = ~cur_q & prev_q;
endmodule

// File: rtl/nvm_word_store.sv
module nvm_word_store
  import nvm_pkg::*;
#(
  parameter int          WORDS        = 64,
  parameter int          DW           = 16,
  parameter logic [15:0] INIT_PATTERN = 16'hA5C3,
  localparam int         IW           = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  act_e          act_i,
  input  logic [IW-1:0] act_idx_i,
  input  logic [DW-1:0] act_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] words [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [7:0]    K8   = 8'(k);
    localparam logic [DW-1:0] INIT = DW'(INIT_PATTERN ^ {K8, K8});
    logic          hit;
    logic [DW-1:0] cell_q;

    assign hit = (act_idx_i == IW'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= INIT;
      end else begin
        case (act_i)
          ACT_CLEAR_ALL:  cell_q <= '1;
          ACT_FILL_ALL:   cell_q <= cell_q & act_data_i;
          ACT_ERASE_WORD: if (hit) cell_q <= '1;
          ACT_WRITE_WORD: if (hit) cell_q <= cell_q & act_data_i;
          default:        cell_q <= cell_q;
        endcase
      end
    end

    assign words[k] = cell_q;
  end

  assign rd_data_o = words[rd_idx_i];

  AST_WRITE_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (act_i == ACT_WRITE_WORD) |=> ((words[$past(act_idx_i)] & ~$past(words[act_idx_i])) == '0)); // R9
  AST_ERASE_SETS_ONES: assert property (@(posedge clk) disable iff (rst)
    (act_i == ACT_ERASE_WORD) |=> (words[$past(act_idx_i)] == '1)); // R8
endmodule

// File: rtl/nvm_frame_ctl.sv
module nvm_frame_ctl
  import nvm_pkg::*;
#(
  parameter int AW = 6,
  parameter int IW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_rise_i,
  input  logic          sel_fall_i,
  input  logic          clk_rise_i,
  input  logic          din_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [IW-1:0] rd_idx_o,
  output act_e          act_o,
  output logic [IW-1:0] act_idx_o,
  output logic [DW-1:0] act_data_o,
  output logic          dout_o
);
  localparam int HDR     = 4;
  localparam int ADR_END = HDR + AW;
  localparam int LAST    = ADR_END + DW;
  localparam int TW      = $clog2(LAST + 1);

  logic [TW-1:0] tick_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          unlocked_q;
  logic          dout_q;

  logic [AW-1:0] addr_shift;
  logic [1:0]    sub_now;
  logic [1:0]    sub_next;

  assign addr_shift = {addr_q[AW-2:0], din_i};
  assign sub_now    = addr_q[AW-1 -: 2];
  assign sub_next   = addr_shift[AW-1 -: 2];
  assign rd_idx_o   = addr_shift[IW-1:0];

  always_comb begin
    act_o = ACT_NONE;
    if (sel_fall_i && unlocked_q) begin
      if (op_q == OP_SPECIAL && sub_now == SUB_CLEAR) begin
        act_o = ACT_CLEAR_ALL;
      end else if (op_q == OP_ERASE) begin
        act_o = ACT_ERASE_WORD;
      end else if (tick_q == TW'(LAST)) begin
        if (op_q == OP_WRITE) begin
          act_o = ACT_WRITE_WORD;
        end else if (op_q == OP_SPECIAL && sub_now == SUB_FILL) begin
          act_o = ACT_FILL_ALL;
        end
      end
    end
  end

  assign act_idx_o  = addr_q[IW-1:0];
  assign act_data_o = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q     <= '0;
      op_q       <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      unlocked_q <= 1'b0;
      dout_q     <= 1'b1;
    end else if (sel_rise_i) begin
      tick_q <= '0;
      op_q   <= '0;
      addr_q <= '0;
    end else if (sel_fall_i) begin
      dout_q <= 1'b1;
    end else if (clk_rise_i) begin
      if (tick_q == '0) begin
        tick_q <= din_i ? TW'(2) : TW'(1);
      end else if (tick_q == TW'(1)) begin
        if (din_i) tick_q <= TW'(2);
      end else if (tick_q < TW'(HDR)) begin
        tick_q <= tick_q + 1'b1;
        op_q   <= {op_q[0], din_i};
      end else if (tick_q < TW'(ADR_END)) begin
        tick_q <= tick_q + 1'b1;
        addr_q <= addr_shift;
        if (tick_q == TW'(ADR_END - 1)) begin
          if (op_q == OP_READ) dout_q <= 1'b0;
          if (op_q == OP_SPECIAL) begin
            if (sub_next == SUB_LOCK)   unlocked_q <= 1'b0;
            if (sub_next == SUB_UNLOCK) unlocked_q <= 1'b1;
          end else begin
            data_q <= rd_data_i;
          end
        end
      end else if (tick_q < TW'(LAST)) begin
        tick_q <= tick_q + 1'b1;
        if (op_q == OP_READ) dout_q <= data_q[DW-1];
        data_q <= {data_q[DW-2:0], din_i};
      end
    end
  end

  assign dout_o = dout_q;

  AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    tick_q <= TW'(LAST)); // R9
  AST_LOW_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    !dout_q |-> (op_q == OP_READ)); // R5
  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (unlocked_q != $past(unlocked_q)) |-> $past(clk_rise_i && op_q == OP_SPECIAL)); // R6
  AST_HIGH_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sel_fall_i |=> dout_q); // R12
endmodule

// File: rtl/uwire_nvm.sv
module uwire_nvm
  import nvm_pkg::*;
#(
  parameter int          WORDS        = 64,
  parameter logic [15:0] INIT_PATTERN = 16'hA5C3
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  localparam int DW = 16;
  localparam int AW = (WORDS <= 64) ? 6 : 8;
  localparam int IW = $clog2(WORDS);

  logic [2:0]    lvl, rise, fall;
  logic          clk_rise;
  act_e          act;
  logic [IW-1:0] act_idx, rd_idx;
  logic [DW-1:0] act_data, rd_data;
  logic          unused_edges;

  nvm_pin_edge #(.N(3)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_i   ({sdi_i, sclk_i, sel_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign clk_rise     = rise[1] & lvl[0];
  assign unused_edges = ^{rise[2], fall[2], fall[1]};

  nvm_frame_ctl #(.AW(AW), .IW(IW), .DW(DW)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .sel_rise_i (rise[0]),
    .sel_fall_i (fall[0]),
    .clk_rise_i (clk_rise),
    .din_i      (lvl[2]),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .act_o      (act),
    .act_idx_o  (act_idx),
    .act_data_o (act_data),
    .dout_o     (sdo_o)
  );

  nvm_word_store #(.WORDS(WORDS), .DW(DW), .INIT_PATTERN(INIT_PATTERN)) u_store (
    .clk        (clk),
    .rst        (rst),
    .act_i      (act),
    .act_idx_i  (act_idx),
    .act_data_i (act_data),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data)
  );

  AST_ACT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_NONE) |-> fall[0]); // R7
endmodule

// File: tb/uwire_nvm_bench.sv
module uwire_nvm_bench;
  localparam int          W    = 16;
  localparam int          LASTB = 26;
  localparam logic [15:0] PAT  = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w;

  always #2 clk = ~clk;

  uwire_nvm #(.WORDS(W), .INIT_PATTERN(PAT)) u_uwire_nvm (
    .clk(clk), .rst(rst), .sel_i(cs), .sclk_i(sk), .sdi_i(di), .sdo_o(do_w)
  );

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_mem [W];
  int m_tick, m_op, m_addr, m_data, m_wen, m_do, m_cs, m_sk;

  task automatic check(input int got, input int exp, input string tag);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < W; i++) m_mem[i] = PAT ^ ((i << 8) | i);
    m_tick = 0; m_op = 0; m_addr = 0; m_data = 0; m_wen = 0; m_do = 1; m_cs = 0; m_sk = 0;
  endtask

  task automatic model_step(input int c, input int s, input int d);
    int sub;
    if (!m_cs && c) begin
      m_tick = 0; m_op = 0; m_addr = 0;
    end else if (m_cs && !c) begin
      sub = (m_addr >> 4) & 3;
      if (m_wen) begin
        if (m_op == 0 && sub == 2) begin
          for (int i = 0; i < W; i++) m_mem[i] = 16'hFFFF;
        end else if (m_op == 3) begin
          m_mem[m_addr % W] = 16'hFFFF;
        end else if (m_tick >= LASTB) begin
          if (m_op == 1) m_mem[m_addr % W] &= m_data;
          else if (m_op == 0 && sub == 1)
            for (int i = 0; i < W; i++) m_mem[i] &= m_data;
        end
      end
      m_do = 1;
    end else if (c && !m_sk && s) begin
      if (m_tick == 0) m_tick = d ? 2 : 1;
      else if (m_tick == 1) begin
        if (d) m_tick = 2;
      end else if (m_tick < 4) begin
        m_tick++; m_op = ((m_op << 1) | d) & 3;
      end else if (m_tick < 10) begin
        m_tick++; m_addr = ((m_addr << 1) | d) & 6'h3F;
        if (m_tick == 10) begin
          if (m_op == 2) m_do = 0;
          if (m_op == 0) begin
            if (((m_addr >> 4) & 3) == 0) m_wen = 0;
            if (((m_addr >> 4) & 3) == 3) m_wen = 1;
          end else m_data = m_mem[m_addr % W];
        end
      end else if (m_tick < LASTB) begin
        m_tick++;
        if (m_op == 2) m_do = (m_data >> 15) & 1;
        m_data = ((m_data << 1) | d) & 16'hFFFF;
      end
    end
    m_cs = c; m_sk = s;
  endtask

  task automatic step(input logic c, input logic s, input logic d);
    bit fell;
    @(negedge clk);
    fell = (m_cs == 1) && !c;
    cs = c; sk = s; di = d;
    model_step(int'(c), int'(s), int'(d));
    repeat (4) @(negedge clk);
    // R12 on a release, otherwise the running scenario's requirement
    check(int'(do_w), m_do, fell ? "R12" : cur_req);
  endtask

  task automatic send_bit(input logic b);
    step(1'b1, 1'b0, b);
    step(1'b1, 1'b1, b);
  endtask

  // lead: extra zeros before the 1; skip: open with a single 1
  task automatic frame(input int op, input int addr, input int ndata, input int dval,
                       input int lead, input bit skip);
    step(1'b1, 1'b0, 1'b0);
    if (skip) send_bit(1'b1);
    else begin
      for (int i = 0; i <= lead; i++) send_bit(1'b0);
      send_bit(1'b1);
    end
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 5; i >= 0; i--) send_bit(addr[i]);
    for (int i = ndata - 1; i >= 0; i--) send_bit(dval[i]);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic read_word(input int addr, input int exp, input string tag);
    logic [15:0] got;
    got = '0;
    step(1'b1, 1'b0, 1'b0);
    send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 5; i >= 0; i--) send_bit(addr[i]);
    check(int'(do_w), 0, "R5");
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b0);
      got = {got[14:0], do_w};
    end
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check(int'(got), exp, tag);
  endtask

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(do_w), 1, "R1");
    read_word(5, PAT ^ 16'h0505, "R1");

    cur_req = "R7";
    frame(1, 3, 16, 16'h0F0F, 0, 0);
    read_word(3, PAT ^ 16'h0303, "R7");

    cur_req = "R6";
    frame(0, 6'b110000, 0, 0, 0, 0);
    cur_req = "R9";
    frame(1, 3, 16, 16'h0F0F, 0, 0);
    read_word(3, (PAT ^ 16'h0303) & 16'h0F0F, "R9");
    frame(1, 4, 10, 10'h000, 0, 0);
    read_word(4, PAT ^ 16'h0404, "R9");
    frame(1, 4, 20, 20'hF00FF, 0, 0);
    read_word(4, (PAT ^ 16'h0404) & 16'hF00F, "R9");

    cur_req = "R8";
    frame(3, 3, 0, 0, 0, 0);
    read_word(3, 16'hFFFF, "R8");

    cur_req = "R3";
    frame(1, 7, 16, 16'h00FF, 3, 0);
    read_word(7, (PAT ^ 16'h0707) & 16'h00FF, "R3");
    frame(1, 8, 16, 16'h0FF0, 0, 1);
    read_word(8, (PAT ^ 16'h0808) & 16'h0FF0, "R3");

    cur_req = "R4";
    frame(3, 6'h25, 0, 0, 0, 0);
    read_word(6'h15, 16'hFFFF, "R4");
    read_word(6'h33, 16'hFFFF, "R4");

    cur_req = "R2";
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b1);
    end
    step(1'b1, 1'b0, 1'b0);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    read_word(9, PAT ^ 16'h0909, "R2");

    cur_req = "R11";
    frame(0, 6'b010000, 8, 8'hFF, 0, 0);
    read_word(9, PAT ^ 16'h0909, "R11");
    frame(0, 6'b010000, 16, 16'hFF00, 0, 0);
    read_word(0, PAT & 16'hFF00, "R11");
    read_word(9, (PAT ^ 16'h0909) & 16'hFF00, "R11");

    cur_req = "R10";
    frame(0, 6'b100000, 0, 0, 0, 0);
    read_word(2, 16'hFFFF, "R10");

    cur_req = "R7";
    frame(1, 1, 16, 16'h1234, 0, 0);
    frame(0, 6'b000000, 0, 0, 0, 0);
    frame(3, 1, 0, 0, 0, 0);
    frame(0, 6'b100000, 0, 0, 0, 0);
    read_word(1, 16'h1234, "R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule